// File: doc/BRIEF.md
# Flash Command Decoder with Identification Mode

This block is the command front end of a NOR flash device. It watches bus write cycles, each an address and a data byte. It recognises a two-write unlock prefix followed by a command byte, and it also recognises single-write commands that work at any address. From these it keeps two pieces of state. The first is a read mode that is either array reads or identification reads. The second is an erase-suspend flag, which is checked against an erase-busy input driven by the erase engine outside the block.

In identification mode a read returns one of three things: the manufacturer code, the device code, or a protect flag for the sector named by the upper address bits. In array mode a read returns the data word supplied from the storage array. The read result is registered and appears on `rd_data` one clock after the read strobe.

The unlock sequencer has three states: `SEQ_IDLE`, `SEQ_UNLK1` (first unlock write seen) and `SEQ_UNLK2` (second unlock write seen). Its transitions are as follows. IDLE goes to UNLK1 on AAh at 555h. UNLK1 goes to UNLK2 on 55h at 2AAh. UNLK2 returns to IDLE on every write, and the write raises the identify command when it is 90h at 555h. Any other write, and any F0h write, returns the sequencer to IDLE. The read-mode machine has the states `RD_ARRAY` and `RD_IDENT`. It moves from ARRAY to IDENT on the identify command, and from IDENT to ARRAY on F0h. The erase machine has the states `ERS_RUN` and `ERS_HELD`. It moves from RUN to HELD on B0h while erase is busy, and from HELD to RUN on 30h. Unlock addresses are compared over the full address width.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `ident_mode` is 0, `erase_suspended` is 0 and `rd_data` is 0.
- R2: `ident_mode` becomes 1 in the cycle after the third of three consecutive writes: AAh at 555h, then 55h at 2AAh, then 90h at 555h.
- R3: A write that breaks the unlock sequence returns the sequencer to idle and leaves the read mode unchanged. A following 90h at 555h then does not enter identification mode.
- R4: In identification mode, reads whose offset field (the address bits below the sector field) equals 00h, 04h, 08h or 0Ch return the manufacturer code zero-extended to 16 bits. These reads may be repeated any number of times.
- R5: In identification mode, a read at offset 01h returns the 16-bit device code.
- R6: In identification mode, a read at offset 02h returns 0001h if bit s of `sector_prot` is 1 and 0000h if it is 0. Here s is the upper $clog2(NSEC) address bits.
- R7: In identification mode, reads at any other offset return 0000h.
- R8: In array mode a read returns the value `array_rdata` had at the read strobe, one cycle later.
- R9: A write of F0h at any address, including one in the middle of an unlock sequence, sets `ident_mode` to 0 in the next cycle and returns the sequencer to idle.
- R10: A write of B0h at any address sets `erase_suspended` only when `erase_busy` is 1. When `erase_busy` is 0 the write is ignored.
- R11: A write of 30h at any address clears `erase_suspended`. A 30h write while not suspended is ignored. A later B0h write with `erase_busy` at 1 suspends again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data (command byte) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address: sector field in the upper bits, offset below |
| array_rdata | input | 16 | Array data for the current read address |
| sector_prot | input | NSEC | Per-sector protect flags |
| erase_busy | input | 1 | External erase engine is erasing |
| rd_data | output | 16 | Registered read result |
| ident_mode | output | 1 | Identification read mode is active |
| erase_suspended | output | 1 | Erase is suspended |

## Verification
The bench builds the block with AW=14 and NSEC=4, so the sector field is address bits 13:12 and the offset field is 12 bits wide. With this setting every sector can be addressed, including the highest one at 3002h. The bench sets a protect pattern that mixes set and clear flags. It also gives the device code a value whose bytes differ, so a byte swap or a truncation of the code shows up. The narrow offset field lets the bench confirm that a read carrying a nonzero sector field still decodes the manufacturer alias.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_UNLK1,
        SEQ_UNLK2
    } seq_state_t;

    typedef enum logic {
        RD_ARRAY,
        RD_IDENT
    } rd_mode_t;

    typedef enum logic {
        ERS_RUN,
        ERS_HELD
    } ers_state_t;

    localparam logic [7:0] CMD_UNLK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B = 8'h55;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESUME = 8'h30;

    localparam logic [11:0] ADR_UNLK_A = 12'h555;
    localparam logic [11:0] ADR_UNLK_B = 12'h2AA;

endpackage

// File: rtl/fcd_unlock_seq.sv
module fcd_unlock_seq
    import fcd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          ident_cmd
);

    localparam logic [AW-1:0] ADDR_A = AW'(ADR_UNLK_A);
    localparam logic [AW-1:0] ADDR_B = AW'(ADR_UNLK_B);

    seq_state_t state_q, state_d;

    logic hit_a, hit_b, hit_id, hit_rst;

    assign hit_a   = (wr_data == CMD_UNLK_A) && (wr_addr == ADDR_A);
    assign hit_b   = (wr_data == CMD_UNLK_B) && (wr_addr == ADDR_B);
    assign hit_id  = (wr_data == CMD_IDENT)  && (wr_addr == ADDR_A);
    assign hit_rst = (wr_data == CMD_RESET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (hit_rst) begin
                state_d = SEQ_IDLE;
            end else begin
                unique case (state_q)
                    SEQ_IDLE:  state_d = hit_a ? SEQ_UNLK1 : SEQ_IDLE;
                    SEQ_UNLK1: state_d = hit_b ? SEQ_UNLK2 : SEQ_IDLE;
                    SEQ_UNLK2: state_d = SEQ_IDLE;
                    default:   state_d = SEQ_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        ident_cmd = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  ident_cmd = 1'b0;
            SEQ_UNLK1: ident_cmd = 1'b0;
            SEQ_UNLK2: ident_cmd = wr_en && hit_id;
            default:   ident_cmd = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcd_mode_ctrl.sv
module fcd_mode_ctrl
    import fcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ident_cmd,
    input  logic reset_cmd,
    input  logic susp_cmd,
    input  logic resume_cmd,
    input  logic erase_busy,
    output logic ident_mode,
    output logic erase_suspended
);

    rd_mode_t   rd_q, rd_d;
    ers_state_t ers_q, ers_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= RD_ARRAY;
            ers_q <= ERS_RUN;
        end else begin
            rd_q  <= rd_d;
            ers_q <= ers_d;
        end
    end

    always_comb begin
        rd_d = rd_q;
        unique case (rd_q)
            RD_ARRAY: if (ident_cmd) rd_d = RD_IDENT;
            RD_IDENT: if (reset_cmd) rd_d = RD_ARRAY;
            default:  rd_d = RD_ARRAY;
        endcase
    end

    always_comb begin
        ers_d = ers_q;
        unique case (ers_q)
            ERS_RUN:  if (susp_cmd && erase_busy) ers_d = ERS_HELD;
            ERS_HELD: if (resume_cmd) ers_d = ERS_RUN;
            default:  ers_d = ERS_RUN;
        endcase
    end

    always_comb begin
        ident_mode      = (rd_q == RD_IDENT);
        erase_suspended = (ers_q == ERS_HELD);
    end

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux #(
    parameter int          AW     = 16,
    parameter int          NSEC   = 8,
    parameter logic [7:0]  MFR_ID = 8'h8C,
    parameter logic [15:0] DEV_ID = 16'h5A49
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    input  logic            ident_mode,
    input  logic [NSEC-1:0] sector_prot,
    input  logic [15:0]     array_rdata,
    output logic [15:0]     rd_data
);

    localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1;
    localparam int OFS_W = AW - SEC_W;

    logic [SEC_W-1:0] sec_idx;
    logic [OFS_W-1:0] ofs;
    logic             prot_bit;
    logic [15:0]      rd_val;

    assign sec_idx = rd_addr[AW-1 -: SEC_W];
    assign ofs     = rd_addr[OFS_W-1:0];

    generate
        if ((1 << SEC_W) == NSEC) begin : g_pow2
            assign prot_bit = sector_prot[sec_idx];
        end else begin : g_ranged
            always_comb begin
                prot_bit = 1'b0;
                for (int i = 0; i < NSEC; i++) begin
                    if (int'(sec_idx) == i) prot_bit = sector_prot[i];
                end
            end
        end
    endgenerate

    always_comb begin
        if (!ident_mode) begin
            rd_val = array_rdata;
        end else if (ofs == OFS_W'('h0) || ofs == OFS_W'('h4) ||
                     ofs == OFS_W'('h8) || ofs == OFS_W'('hC)) begin
            rd_val = {8'h00, MFR_ID};
        end else if (ofs == OFS_W'('h1)) begin
            rd_val = DEV_ID;
        end else if (ofs == OFS_W'('h2)) begin
            rd_val = {15'h0000, prot_bit};
        end else begin
            rd_val = 16'h0000;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= 16'h0000;
        end else if (rd_en) begin
            rd_data <= rd_val;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int          AW     = 16,
    parameter int          NSEC   = 8,
    parameter logic [7:0]  MFR_ID = 8'h8C,
    parameter logic [15:0] DEV_ID = 16'h5A49
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    input  logic [15:0]     array_rdata,
    input  logic [NSEC-1:0] sector_prot,
    input  logic            erase_busy,
    output logic [15:0]     rd_data,
    output logic            ident_mode,
    output logic            erase_suspended
);

    logic ident_cmd;
    logic reset_cmd;
    logic susp_cmd;
    logic resume_cmd;

    assign reset_cmd  = wr_en && (wr_data == CMD_RESET);
    assign susp_cmd   = wr_en && (wr_data == CMD_SUSP);
    assign resume_cmd = wr_en && (wr_data == CMD_RESUME);

    fcd_unlock_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ident_cmd (ident_cmd)
    );

    fcd_mode_ctrl u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .ident_cmd       (ident_cmd),
        .reset_cmd       (reset_cmd),
        .susp_cmd        (susp_cmd),
        .resume_cmd      (resume_cmd),
        .erase_busy      (erase_busy),
        .ident_mode      (ident_mode),
        .erase_suspended (erase_suspended)
    );

    fcd_read_mux #(
        .AW     (AW),
        .NSEC   (NSEC),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_rmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .ident_mode  (ident_mode),
        .sector_prot (sector_prot),
        .array_rdata (array_rdata),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int          AW     = 16,
    parameter int          NSEC   = 8,
    parameter logic [7:0]  MFR_ID = 8'h8C,
    parameter logic [15:0] DEV_ID = 16'h5A49
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [7:0]      wr_data,
    input logic            rd_en,
    input logic [AW-1:0]   rd_addr,
    input logic [15:0]     array_rdata,
    input logic [NSEC-1:0] sector_prot,
    input logic            erase_busy,
    input logic [15:0]     rd_data,
    input logic            ident_mode,
    input logic            erase_suspended
);

    localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1;
    localparam int OFS_W = AW - SEC_W;

    logic [OFS_W-1:0] c_ofs;
    logic [SEC_W-1:0] c_sec;
    logic             c_mfr_ofs;

    assign c_ofs     = rd_addr[OFS_W-1:0];
    assign c_sec     = rd_addr[AW-1 -: SEC_W];
    assign c_mfr_ofs = (c_ofs == OFS_W'('h0)) || (c_ofs == OFS_W'('h4)) ||
                       (c_ofs == OFS_W'('h8)) || (c_ofs == OFS_W'('hC));

    p_ident_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ident_mode) |-> $past(wr_en && wr_data == 8'h90 && wr_addr == AW'(12'h555)));

    p_mfr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ident_mode && c_mfr_ofs) |=> (rd_data == {8'h00, MFR_ID}));

    p_dev_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ident_mode && c_ofs == OFS_W'('h1)) |=> (rd_data == DEV_ID));

    p_sector_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ident_mode && c_ofs == OFS_W'('h2) && int'(c_sec) < NSEC)
        |=> (rd_data == {15'h0000, $past(sector_prot[c_sec])}));

    p_array_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ident_mode) |=> (rd_data == $past(array_rdata)));

    p_reset_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'hF0) |=> !ident_mode);

    p_susp_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_suspended) |-> $past(wr_en && wr_data == 8'hB0 && erase_busy));

    p_resume_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_suspended && wr_en && wr_data == 8'h30) |=> !erase_suspended);

    p_resume_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_suspended) |-> $past(wr_en && wr_data == 8'h30));

endmodule

bind flash_cmd_decoder fcd_checker #(
    .AW     (AW),
    .NSEC   (NSEC),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .rd_en           (rd_en),
    .rd_addr         (rd_addr),
    .array_rdata     (array_rdata),
    .sector_prot     (sector_prot),
    .erase_busy      (erase_busy),
    .rd_data         (rd_data),
    .ident_mode      (ident_mode),
    .erase_suspended (erase_suspended)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam int          AW   = 14;
    localparam int          NSEC = 4;
    localparam logic [7:0]  MFR  = 8'h8C;
    localparam logic [15:0] DEV  = 16'hC3A5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [15:0]     array_rdata = 16'h0000;
    logic [NSEC-1:0] sector_prot = 4'b1010;
    logic            erase_busy = 1'b0;
    logic [15:0]     rd_data;
    logic            ident_mode;
    logic            erase_suspended;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.AW(AW), .NSEC(NSEC), .MFR_ID(MFR), .DEV_ID(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .array_rdata(array_rdata),
        .sector_prot(sector_prot), .erase_busy(erase_busy), .rd_data(rd_data),
        .ident_mode(ident_mode), .erase_suspended(erase_suspended)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [15:0] q);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic enter_ident();
        bus_wr(14'h555, 8'hAA);
        bus_wr(14'h2AA, 8'h55);
        bus_wr(14'h555, 8'h90);
    endtask

    task automatic t_reset_state();
        check("R1 ident_mode", {15'b0, ident_mode}, 16'h0);
        check("R1 erase_suspended", {15'b0, erase_suspended}, 16'h0);
        check("R1 rd_data", rd_data, 16'h0000);
    endtask

    task automatic t_array_read();
        logic [15:0] q;
        array_rdata = 16'hBEEF;
        bus_rd(14'h0001, q);
        check("R8 array read", q, 16'hBEEF);
        array_rdata = 16'h1234;
        bus_rd(14'h0002, q);
        check("R8 array read 2", q, 16'h1234);
    endtask

    task automatic t_broken_unlock();
        logic [15:0] q;
        bus_wr(14'h555, 8'hAA);
        bus_wr(14'h2AB, 8'h55);
        bus_wr(14'h555, 8'h90);
        check("R3 wrong second address", {15'b0, ident_mode}, 16'h0);
        bus_wr(14'h555, 8'hAA);
        bus_wr(14'h2AA, 8'h12);
        bus_wr(14'h555, 8'h90);
        check("R3 wrong second data", {15'b0, ident_mode}, 16'h0);
        bus_wr(14'h1555, 8'hAA);
        bus_wr(14'h2AA, 8'h55);
        bus_wr(14'h555, 8'h90);
        check("R3 upper address bits set", {15'b0, ident_mode}, 16'h0);
        array_rdata = 16'h7777;
        bus_rd(14'h0000, q);
        check("R3 still array mode", q, 16'h7777);
    endtask

    task automatic t_ident_reads();
        logic [15:0] q;
        enter_ident();
        check("R2 entry", {15'b0, ident_mode}, 16'h1);
        for (int rep = 0; rep < 2; rep++) begin
            bus_rd(14'h0000, q); check("R4 mfr at 00", q, 16'h008C);
            bus_rd(14'h0004, q); check("R4 mfr at 04", q, 16'h008C);
            bus_rd(14'h0008, q); check("R4 mfr at 08", q, 16'h008C);
            bus_rd(14'h000C, q); check("R4 mfr at 0C", q, 16'h008C);
        end
        bus_rd(14'h2004, q); check("R4 mfr with sector bits", q, 16'h008C);
        bus_rd(14'h0001, q); check("R5 device code", q, 16'hC3A5);
        bus_rd(14'h0002, q); check("R6 sector 0 clear", q, 16'h0000);
        bus_rd(14'h1002, q); check("R6 sector 1 set", q, 16'h0001);
        bus_rd(14'h2002, q); check("R6 sector 2 clear", q, 16'h0000);
        bus_rd(14'h3002, q); check("R6 sector 3 set", q, 16'h0001);
        bus_rd(14'h0003, q); check("R7 offset 03", q, 16'h0000);
        bus_rd(14'h0010, q); check("R7 offset 10", q, 16'h0000);
        bus_wr(14'h555, 8'hAA);
        bus_wr(14'h123, 8'h00);
        check("R3 break keeps ident mode", {15'b0, ident_mode}, 16'h1);
    endtask

    task automatic t_reset_cmd();
        logic [15:0] q;
        bus_wr(14'h0123, 8'hF0);
        check("R9 exit ident", {15'b0, ident_mode}, 16'h0);
        array_rdata = 16'hA5A5;
        bus_rd(14'h0001, q);
        check("R9 back to array", q, 16'hA5A5);
        bus_wr(14'h555, 8'hAA);
        bus_wr(14'h2AA, 8'hF0);
        bus_wr(14'h2AA, 8'h55);
        bus_wr(14'h555, 8'h90);
        check("R9 F0 resets sequencer", {15'b0, ident_mode}, 16'h0);
    endtask

    task automatic t_suspend_resume();
        erase_busy = 1'b0;
        bus_wr(14'h0000, 8'hB0);
        check("R10 suspend ignored when idle", {15'b0, erase_suspended}, 16'h0);
        erase_busy = 1'b1;
        bus_wr(14'h2F3F, 8'hB0);
        check("R10 suspend while busy", {15'b0, erase_suspended}, 16'h1);
        bus_wr(14'h0777, 8'h30);
        check("R11 resume clears", {15'b0, erase_suspended}, 16'h0);
        bus_wr(14'h0001, 8'h30);
        check("R11 extra resume ignored", {15'b0, erase_suspended}, 16'h0);
        bus_wr(14'h0555, 8'hB0);
        check("R11 suspend again", {15'b0, erase_suspended}, 16'h1);
        bus_wr(14'h0555, 8'hF0);
        check("R11 F0 keeps suspend", {15'b0, erase_suspended}, 16'h1);
        bus_wr(14'h3FFF, 8'h30);
        check("R11 final resume", {15'b0, erase_suspended}, 16'h0);
        erase_busy = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_array_read();
        t_broken_unlock();
        t_ident_reads();
        t_reset_cmd();
        t_suspend_resume();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule